// File: doc/BRIEF.md
# IN Endpoint Interrupt Status and Mask Register

This block keeps the interrupt state of one IN endpoint of a USB device controller. The endpoint engine reports events as single-cycle pulses: a NAK handshake, a dropped isochronous packet, a transmit underrun, an IN token that found the wrong data or no data, a timeout, a bus error, endpoint disable and transfer completion. Each pulse sets its own sticky status bit. The bit stays set until software writes a 1 to that position in the status register.

Two status bits are not latched events. They are levels taken from current core state. One shows whether the transmit FIFO has drained to a selectable level. The other shows that the core has taken the endpoint NAK request into account. A mask register picks which status bits may interrupt. The block merges the enabled bits into a single registered endpoint interrupt line.

Software reaches both registers through one port. `reg_sel` picks the status register (0) or the mask register (1). The port has a write strobe and a read path that does not wait for a clock.

Top module: `inep_irq_regs`

## Requirements
- R1: Status bits 31:14, 12, 10 and 9 always read 0. Writes to them have no effect. Writes to the read-only bits 7 and 6 do not change them.
- R2: Each event pulse sets its sticky status bit on the next clock edge. The positions are NAK 13, packet dropped 11, underrun 8, token with endpoint mismatch 5, token with FIFO empty 4, timeout 3, bus error 2, endpoint disabled 1 and transfer complete 0. A set bit stays set until a status write with a 1 in that position clears it. Writing 0 has no effect.
- R3: If an event pulse and a write-1 clear reach the same sticky bit in the same cycle, the bit ends up set.
- R4: The underrun bit (8) sets only when its event pulse arrives while `thresh_en` is 1.
- R5: Bit 7 follows `fifo_level` without delay. When `empty_lvl_sel` is 0, bit 7 is 1 while the level is at most FIFO_DEPTH/2. When `empty_lvl_sel` is 1, bit 7 is 1 only while the level is 0.
- R6: Bit 6 becomes 1 on the edge after a `nak_sampled` pulse. It becomes 0 on the edge after a `cnak_write` pulse. If both pulses arrive together, the bit becomes 1.
- R7: The mask register (`reg_sel`=1) is read/write and resets to 0. It keeps only the positions 13, 8, 7, 6, 5, 4, 3, 2, 1 and 0. All other mask positions read 0.
- R8: `ep_irq` is the OR over all bits of (status AND mask). It is registered, so it reflects status and mask one clock after they change.
- R9: The packet-dropped bit (11) never causes `ep_irq` to assert.
- R10: After reset, every sticky bit, bit 6, the mask register and `ep_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status register, 1 selects the mask register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ev_nak | input | 1 | NAK handshake, or zero-length isochronous IN sent for lack of data |
| ev_pkt_drop | input | 1 | Isochronous OUT packet dropped |
| ev_underrun | input | 1 | Transmit FIFO underrun detected |
| ev_tok_mismatch | input | 1 | IN token while the shared FIFO head belongs to another endpoint |
| ev_tok_empty | input | 1 | IN token while the associated FIFO is empty |
| ev_timeout | input | 1 | Timeout condition |
| ev_bus_err | input | 1 | Bus error on the system side |
| ev_ep_disabled | input | 1 | Endpoint has been disabled |
| ev_xfer_done | input | 1 | Transfer completed |
| fifo_level | input | LVL_W (5) | Words currently held in the transmit FIFO |
| thresh_en | input | 1 | Thresholding enabled; allows the underrun bit to set |
| empty_lvl_sel | input | 1 | 0: half-empty level, 1: completely empty level |
| nak_sampled | input | 1 | Core has sampled the endpoint NAK bit set |
| cnak_write | input | 1 | Software wrote the clear-NAK control |
| ep_irq | output | 1 | Endpoint interrupt line |

## Verification
The assertions check several rules on every cycle:
- reserved status positions stay zero;
- an event pulse always leaves its bit set, even against a clear;
- a lone clear removes the bit;
- the underrun bit stays low while thresholding is off;
- the empty flag is up whenever the FIFO is empty;
- the mask changes only on a mask write;
- a clear-NAK drops the NAK-effective flag;
- the interrupt line rises only after some enabled status bit was set, and never because of the packet-dropped bit.

Other properties need the bench's scenarios. These are:
- the exact half-depth threshold in both level modes;
- that reads of reserved and read-only positions stay unchanged after writes of all ones;
- the one-cycle interrupt latency after a mask change;
- the reset values;
- the agreement of every bit with an independent model over long random mixes of events and register writes.

// File: rtl/inep_irq_pkg.sv
package inep_irq_pkg;

  localparam int unsigned REG_W = 32;

  // status bit positions (software-visible, fixed)
  localparam int unsigned B_XFER      = 0;
  localparam int unsigned B_EPDIS     = 1;
  localparam int unsigned B_BUSERR    = 2;
  localparam int unsigned B_TIMEOUT   = 3;
  localparam int unsigned B_TOK_EMPTY = 4;
  localparam int unsigned B_TOK_MISM  = 5;
  localparam int unsigned B_NAK_EFF   = 6;
  localparam int unsigned B_TXF_EMPTY = 7;
  localparam int unsigned B_UNDERRUN  = 8;
  localparam int unsigned B_PKT_DROP  = 11;
  localparam int unsigned B_NAK       = 13;

  // single-cycle event pulses from the endpoint engine
  typedef struct packed {
    logic nak;
    logic pkt_drop;
    logic underrun;
    logic tok_mism;
    logic tok_empty;
    logic timeout;
    logic bus_err;
    logic ep_dis;
    logic xfer_done;
  } inep_evt_t;

  function automatic logic [REG_W-1:0] bit_at(input int unsigned pos);
    logic [REG_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  // positions held in flops and cleared by writing 1
  function automatic logic [REG_W-1:0] sticky_positions();
    return bit_at(B_NAK) | bit_at(B_PKT_DROP) | bit_at(B_UNDERRUN) |
           bit_at(B_TOK_MISM) | bit_at(B_TOK_EMPTY) | bit_at(B_TIMEOUT) |
           bit_at(B_BUSERR) | bit_at(B_EPDIS) | bit_at(B_XFER);
  endfunction

  // positions derived live from core state
  function automatic logic [REG_W-1:0] live_positions();
    return bit_at(B_TXF_EMPTY) | bit_at(B_NAK_EFF);
  endfunction

  // positions that own a mask bit and may interrupt
  function automatic logic [REG_W-1:0] maskable_positions();
    return (sticky_positions() | live_positions()) & ~bit_at(B_PKT_DROP);
  endfunction

  // map event pulses onto status positions; underrun gated by thresholding
  function automatic logic [REG_W-1:0] evt_to_vec(input inep_evt_t e,
                                                  input logic thr_en);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_NAK]       = e.nak;
    v[B_PKT_DROP]  = e.pkt_drop;
    v[B_UNDERRUN]  = e.underrun & thr_en;
    v[B_TOK_MISM]  = e.tok_mism;
    v[B_TOK_EMPTY] = e.tok_empty;
    v[B_TIMEOUT]   = e.timeout;
    v[B_BUSERR]    = e.bus_err;
    v[B_EPDIS]     = e.ep_dis;
    v[B_XFER]      = e.xfer_done;
    return v;
  endfunction

  // FIFO drained to the selected level: fully empty, or at most half full
  function automatic logic txf_drained(input int unsigned lvl,
                                       input int unsigned depth,
                                       input logic full_only);
    if (full_only) return (lvl == 0);
    return ((lvl * 2) <= depth);
  endfunction

endpackage

// File: rtl/inep_sticky_bank.sv
module inep_sticky_bank #(
  parameter int unsigned    W    = 32,
  parameter logic [W-1:0]   KEEP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);

  logic [W-1:0] spare_unused;
  assign spare_unused = (set_vec | clr_vec) & ~KEEP;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q[i] <= 1'b0;
        else if (set_vec[i]) q[i] <= 1'b1;   // set has priority over clear
        else if (clr_vec[i]) q[i] <= 1'b0;
      end
    end else begin : g_zero
      assign q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/inep_nak_effect.sv
module inep_nak_effect (
  input  logic clk,
  input  logic rst_n,
  input  logic nak_sampled,
  input  logic cnak_write,
  output logic nak_eff
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           nak_eff <= 1'b0;
    else if (nak_sampled) nak_eff <= 1'b1;
    else if (cnak_write)  nak_eff <= 1'b0;
  end

endmodule

// File: rtl/inep_irq_merge.sv
module inep_irq_merge #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] ELIG = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         irq
);

  logic [W-1:0] pending;
  assign pending = status & mask & ELIG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |pending;
  end

endmodule

// File: rtl/inep_irq_regs.sv
module inep_irq_regs
  import inep_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_nak,
  input  logic             ev_pkt_drop,
  input  logic             ev_underrun,
  input  logic             ev_tok_mismatch,
  input  logic             ev_tok_empty,
  input  logic             ev_timeout,
  input  logic             ev_bus_err,
  input  logic             ev_ep_disabled,
  input  logic             ev_xfer_done,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             thresh_en,
  input  logic             empty_lvl_sel,
  input  logic             nak_sampled,
  input  logic             cnak_write,
  output logic             ep_irq
);

  localparam logic [REG_W-1:0] STICKY   = sticky_positions();
  localparam logic [REG_W-1:0] MASKABLE = maskable_positions();

  // named internal events
  inep_evt_t        evt;
  logic             underrun_gated;
  logic [REG_W-1:0] sticky_set;
  logic [REG_W-1:0] w1c_status;
  logic             wr_status;
  logic             wr_mask;
  logic [REG_W-1:0] sticky_q;
  logic [REG_W-1:0] mask_q;
  logic             txf_empty_lvl;
  logic             nak_eff;
  logic [REG_W-1:0] status_vec;

  assign evt.nak       = ev_nak;
  assign evt.pkt_drop  = ev_pkt_drop;
  assign evt.underrun  = ev_underrun;
  assign evt.tok_mism  = ev_tok_mismatch;
  assign evt.tok_empty = ev_tok_empty;
  assign evt.timeout   = ev_timeout;
  assign evt.bus_err   = ev_bus_err;
  assign evt.ep_dis    = ev_ep_disabled;
  assign evt.xfer_done = ev_xfer_done;

  assign underrun_gated = ev_underrun & thresh_en;
  assign sticky_set     = evt_to_vec(evt, thresh_en);

  assign wr_status  = reg_wr & ~reg_sel;
  assign wr_mask    = reg_wr &  reg_sel;
  assign w1c_status = wr_status ? (reg_wdata & STICKY) : '0;

  inep_sticky_bank #(
    .W    (REG_W),
    .KEEP (STICKY)
  ) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (sticky_set),
    .clr_vec (w1c_status),
    .q       (sticky_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata & MASKABLE;
  end

  assign txf_empty_lvl = txf_drained(int'(fifo_level), FIFO_DEPTH, empty_lvl_sel);

  inep_nak_effect u_nak (
    .clk         (clk),
    .rst_n       (rst_n),
    .nak_sampled (nak_sampled),
    .cnak_write  (cnak_write),
    .nak_eff     (nak_eff)
  );

  always_comb begin
    status_vec              = sticky_q;
    status_vec[B_TXF_EMPTY] = txf_empty_lvl;
    status_vec[B_NAK_EFF]   = nak_eff;
  end

  inep_irq_merge #(
    .W    (REG_W),
    .ELIG (MASKABLE)
  ) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_vec),
    .mask   (mask_q),
    .irq    (ep_irq)
  );

  assign reg_rdata = reg_sel ? mask_q : status_vec;

endmodule

// File: rtl/inep_irq_checker.sv
module inep_irq_checker
  import inep_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [31:0]      reg_wdata,
  input logic             ev_xfer_done,
  input logic             thresh_en,
  input logic [LVL_W-1:0] fifo_level,
  input logic             nak_sampled,
  input logic             cnak_write,
  input logic [31:0]      status_vec,
  input logic [31:0]      mask_q,
  input logic             ep_irq
);

  localparam logic [31:0] RSVD = ~(sticky_positions() | live_positions());

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vec & RSVD) == '0);

  p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_wdata[B_XFER] && !ev_xfer_done) |=> !status_vec[B_XFER]);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_done |=> status_vec[B_XFER]);

  p_underrun_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!thresh_en && !status_vec[B_UNDERRUN]) |=> !status_vec[B_UNDERRUN]);

  p_empty_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == '0) |-> status_vec[B_TXF_EMPTY]);

  p_cnak_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnak_write && !nak_sampled) |=> !status_vec[B_NAK_EFF]);

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel) |=> $stable(mask_q));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ep_irq) |-> $past((status_vec & mask_q) != '0));

  p_drop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_vec & mask_q & ~bit_at(B_PKT_DROP)) == '0) |=> !ep_irq);

endmodule

bind inep_irq_regs inep_irq_checker #(.LVL_W(LVL_W)) u_inep_irq_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_sel      (reg_sel),
  .reg_wdata    (reg_wdata),
  .ev_xfer_done (ev_xfer_done),
  .thresh_en    (thresh_en),
  .fifo_level   (fifo_level),
  .nak_sampled  (nak_sampled),
  .cnak_write   (cnak_write),
  .status_vec   (status_vec),
  .mask_q       (mask_q),
  .ep_irq       (ep_irq)
);

// File: tb/test_inep_irq_regs.sv
`timescale 1ns/1ps
module test_inep_irq_regs;

  localparam int DEPTH = 16;
  localparam int LW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          ev_nak = 0, ev_pkt_drop = 0, ev_underrun = 0, ev_tok_mismatch = 0;
  logic          ev_tok_empty = 0, ev_timeout = 0, ev_bus_err = 0, ev_ep_disabled = 0;
  logic          ev_xfer_done = 0;
  logic [LW-1:0] fifo_level = 5'd16;
  logic          thresh_en = 0, empty_lvl_sel = 0, nak_sampled = 0, cnak_write = 0;
  logic          ep_irq;

  always #4 clk = ~clk;

  inep_irq_regs i_inep_irq_regs (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
    .ev_nak, .ev_pkt_drop, .ev_underrun, .ev_tok_mismatch, .ev_tok_empty,
    .ev_timeout, .ev_bus_err, .ev_ep_disabled, .ev_xfer_done,
    .fifo_level, .thresh_en, .empty_lvl_sel, .nak_sampled, .cnak_write, .ep_irq
  );

  // reference model state
  bit [31:0] m_sticky, m_mask;
  bit        m_nakeff, m_irq;
  int        vectors = 0, errors = 0;
  string     cur_req = "R10";
  bit        done = 0;

  function automatic bit m_empty();
    if (empty_lvl_sel) return fifo_level == 0;
    return int'(fifo_level) <= DEPTH / 2;
  endfunction

  function automatic bit [31:0] m_status();
    bit [31:0] s;
    s = m_sticky;
    s[7] = m_empty();
    s[6] = m_nakeff;
    return s;
  endfunction

  function automatic bit [31:0] m_events();
    bit [31:0] e = '0;
    e[13] = ev_nak;      e[11] = ev_pkt_drop;
    e[8]  = ev_underrun && thresh_en;
    e[5]  = ev_tok_mismatch; e[4] = ev_tok_empty;
    e[3]  = ev_timeout;  e[2] = ev_bus_err;
    e[1]  = ev_ep_disabled;  e[0] = ev_xfer_done;
    return e;
  endfunction

  task automatic cyc();
    bit [31:0] clr, exp_rd;
    @(posedge clk);
    if (!rst_n) begin
      m_sticky = 0; m_mask = 0; m_nakeff = 0; m_irq = 0;
    end else begin
      m_irq = 0;
      for (int b = 0; b < 32; b++)
        if (b != 11 && m_status()[b] && m_mask[b]) m_irq = 1;
      clr = (reg_wr && !reg_sel) ? (reg_wdata & 32'h0000_293F) : 32'h0;
      m_sticky = (m_sticky & ~clr) | m_events();
      if (reg_wr && reg_sel) m_mask = reg_wdata & 32'h0000_21FF;
      if (nak_sampled)     m_nakeff = 1;
      else if (cnak_write) m_nakeff = 0;
    end
    @(negedge clk);
    exp_rd = reg_sel ? m_mask : m_status();
    vectors++;
    if (reg_rdata !== exp_rd || ep_irq !== m_irq) begin
      errors++;
      $display("FAIL %s: rdata=%08h irq=%0b expected rdata=%08h irq=%0b",
               cur_req, reg_rdata, ep_irq, exp_rd, m_irq);
    end
    reg_wr = 0; ev_nak = 0; ev_pkt_drop = 0; ev_underrun = 0; ev_tok_mismatch = 0;
    ev_tok_empty = 0; ev_timeout = 0; ev_bus_err = 0; ev_ep_disabled = 0;
    ev_xfer_done = 0; nak_sampled = 0; cnak_write = 0;
  endtask

  task automatic wr(input bit sel, input bit [31:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R10: reset state, both registers
    cur_req = "R10";
    reg_sel = 0; cyc(); reg_sel = 1; cyc(); reg_sel = 0; cyc();
    rst_n = 1; cyc();
    reg_sel = 1; cyc(); reg_sel = 0;

    // R1: ones written to reserved and read-only positions
    cur_req = "R1";
    fifo_level = 5'd16; wr(0, 32'hFFFF_FFFF); reg_wr = 0; cyc();

    // R2: each event sets its bit; writing 0 keeps it; writing 1 clears it
    cur_req = "R2";
    thresh_en = 1;
    ev_nak = 1; cyc(); ev_pkt_drop = 1; cyc(); ev_underrun = 1; cyc();
    ev_tok_mismatch = 1; cyc(); ev_tok_empty = 1; cyc(); ev_timeout = 1; cyc();
    ev_bus_err = 1; cyc(); ev_ep_disabled = 1; cyc(); ev_xfer_done = 1; cyc();
    wr(0, 32'h0); cyc();
    wr(0, 32'h0000_0021); cyc();
    wr(0, 32'hFFFF_FFFF); cyc();

    // R3: event and clear together on the same bit
    cur_req = "R3";
    ev_timeout = 1; cyc();
    ev_timeout = 1; wr(0, 32'h0000_0008); cyc();
    wr(0, 32'h0000_0008); cyc();

    // R4: underrun gated by thresholding
    cur_req = "R4";
    thresh_en = 0; ev_underrun = 1; cyc(); cyc();
    thresh_en = 1; ev_underrun = 1; cyc();
    wr(0, 32'h0000_0100);

    // R5: empty level boundaries in both modes
    cur_req = "R5";
    for (int sel = 0; sel < 2; sel++) begin
      empty_lvl_sel = sel[0];
      foreach (fifo_level[i]) begin end
      fifo_level = 5'd0;  cyc();
      fifo_level = 5'd1;  cyc();
      fifo_level = 5'd8;  cyc();
      fifo_level = 5'd9;  cyc();
      fifo_level = 5'd16; cyc();
    end
    empty_lvl_sel = 0;

    // R6: NAK effective set, clear, simultaneous
    cur_req = "R6";
    nak_sampled = 1; cyc(); cyc();
    cnak_write = 1; cyc();
    nak_sampled = 1; cnak_write = 1; cyc();
    cnak_write = 1; cyc();

    // R7: mask read/write, unused positions read 0
    cur_req = "R7";
    reg_sel = 1;
    wr(1, 32'hFFFF_FFFF); wr(1, 32'h0000_0A5A); wr(1, 32'h0); reg_sel = 0;

    // R8: masked events raise the line one cycle later
    cur_req = "R8";
    wr(1, 32'h0000_0001); reg_sel = 0;
    ev_xfer_done = 1; cyc(); cyc();
    wr(0, 32'h0000_0001); cyc();
    fifo_level = 5'd2; wr(1, 32'h0000_0080); reg_sel = 0; cyc();
    fifo_level = 5'd16; cyc(); cyc();

    // R9: packet dropped never interrupts even with all mask bits set
    cur_req = "R9";
    wr(1, 32'hFFFF_FFFF); reg_sel = 0;
    ev_pkt_drop = 1; cyc(); cyc(); cyc();
    wr(0, 32'h0000_0800); wr(1, 32'h0); reg_sel = 0;

    // R8: random mixture checked against the model on every cycle
    cur_req = "R8";
    for (int n = 0; n < 4000; n++) begin
      ev_nak = ($urandom_range(0, 15) == 0); ev_pkt_drop = ($urandom_range(0, 15) == 0);
      ev_underrun = ($urandom_range(0, 15) == 0); ev_tok_mismatch = ($urandom_range(0, 15) == 0);
      ev_tok_empty = ($urandom_range(0, 15) == 0); ev_timeout = ($urandom_range(0, 15) == 0);
      ev_bus_err = ($urandom_range(0, 15) == 0); ev_ep_disabled = ($urandom_range(0, 15) == 0);
      ev_xfer_done = ($urandom_range(0, 15) == 0);
      nak_sampled = ($urandom_range(0, 15) == 0); cnak_write = ($urandom_range(0, 15) == 0);
      thresh_en = $urandom_range(0, 1); empty_lvl_sel = $urandom_range(0, 1);
      fifo_level = LW'($urandom_range(0, DEPTH));
      reg_sel = $urandom_range(0, 1);
      reg_wr = ($urandom_range(0, 7) == 0); reg_wdata = $urandom();
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule